// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Shutdown

This block decides which of a small set of analog channels a converter samples next, tracks how long each conversion runs, and manages a low-power state between conversions. A conversion begins on the falling edge of the conversion-start input. It runs for a fixed number of clock cycles, and a busy flag covers that whole interval. When busy drops, the result and the identity of the channel it belongs to can be read.

A small configuration register is loaded through a simple write strobe. It holds a channel address, a sequencing enable and a power-down request. With sequencing disabled, every conversion uses the address from the most recent write. With sequencing enabled, successive conversions walk upward from channel 0 to the written address and then wrap back to 0. With power-down requested, the block drops into shutdown once each conversion completes. It stays there until conversion-start rises, and then needs a fixed power-up interval before the next conversion is accepted.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, busy is 0, the channel output is 0 and the power state is active (encoding 2'b00).
- R2: A falling edge of conversion start, seen while idle and active, raises busy from the next cycle. Busy then stays high for exactly CONV_CYCLES cycles.
- R3: With sequencing disabled, each conversion reports the channel address held by the most recent configuration write.
- R4: With sequencing enabled and address N, successive conversions use channels 0, 1, …, N, then 0 again, and repeat in that order.
- R5: Every configuration write restarts the sequence, so the next sequenced conversion uses channel 0.
- R6: A configuration write made during a conversion leaves that conversion's channel unchanged and takes effect from the next conversion start.
- R7: Falling edges of conversion start while busy is high are ignored. They neither lengthen the conversion, change its channel nor advance the sequence.
- R8: If power-down was requested when a conversion started, the power state becomes shutdown (2'b01) in the same cycle busy falls. Otherwise it stays active.
- R9: In shutdown, falling edges of conversion start are ignored. A rising edge moves the power state to powering-up (2'b10) for exactly PWRUP_CYCLES cycles, after which it returns to active.
- R10: A falling edge during power-up starts no conversion, and the block accepts normal conversions once it is active again.
- R11: The channel output is latched at conversion start and holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Conversion start; falling edge starts, rising edge wakes from shutdown |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_addr | input | CH_W | Channel address (fixed channel, or last channel of the sequence) |
| cfg_seq_en | input | 1 | 1 = step through channels 0..address |
| cfg_pd | input | 1 | 1 = enter shutdown after each conversion |
| busy | output | 1 | High while a conversion is in progress |
| conv_ch | output | CH_W | Channel of the current or most recent conversion |
| pwr_state | output | 2 | 00 active, 01 shutdown, 10 powering up |

## Verification
On every cycle, the assertions check four things. Busy and a non-active power state never overlap. Busy rises only after conversion start was sampled low, and each busy run lasts exactly the conversion length. Shutdown is entered only as busy falls, and power-up is entered only on a sampled-high start and lasts exactly the power-up length. The channel is also checked to be stable while busy. Only the bench scenarios can show the channel values themselves: the fixed-address sweep, the wrapping sequences for each last channel, the restart on write, the deferred effect of a mid-conversion write, and the ignored edges during conversion, shutdown and power-up.

// File: rtl/cseq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes: the power state is exported as a plain 2-bit port.
package cseq_pkg;
    typedef enum logic [1:0] {
        PWR_ACTIVE   = 2'b00,
        PWR_SHUTDOWN = 2'b01,
        PWR_WAKING   = 2'b10
    } pwr_state_t;
endpackage

// File: rtl/cseq_edge.sv
// Edge detector for the conversion-start line.
// Optionally synchronises the line first through SYNC_STAGES flops.
// Assumes: with SYNC_STAGES = 0 the input is already synchronous to clk.
module cseq_edge #(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall,
    output logic rise
);
    logic [SYNC_STAGES:0] chain;
    logic                 prev;
    logic                 cur;

    assign chain[0] = din;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            // Shift the line through one synchroniser stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i+1] <= 1'b0;
                else        chain[i+1] <= chain[i];
            end
        end
    endgenerate

    assign cur = chain[SYNC_STAGES];

    // Remember the previous sample to find edges.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= cur;
    end

    assign fall = prev & ~cur;
    assign rise = ~prev & cur;
endmodule

// File: rtl/cseq_chan_sel.sv
// Configuration holder and channel selector.
// Keeps the address, the sequencing enable and the power-down request.
// Presents the channel the next accepted conversion should use.
// Assumes: take is pulsed once per accepted conversion start.
module cseq_chan_sel #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [CH_W-1:0] wr_addr,
    input  logic            wr_seq,
    input  logic            wr_pd,
    input  logic            take,
    output logic [CH_W-1:0] ch_next,
    output logic            pd_cfg
);
    logic [CH_W-1:0] addr_q;
    logic            seq_q;
    logic [CH_W-1:0] ptr;
    logic [CH_W-1:0] ptr_inc;

    assign ptr_inc = (ptr == addr_q) ? '0 : CH_W'(ptr + 1'b1);

    // Load the configuration on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            seq_q  <= 1'b0;
            pd_cfg <= 1'b0;
        end else if (wr) begin
            addr_q <= wr_addr;
            seq_q  <= wr_seq;
            pd_cfg <= wr_pd;
        end
    end

    // Sequence pointer: restart on a write, step on each sequenced start.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr <= '0;
        else if (wr)             ptr <= '0;
        else if (take && seq_q)  ptr <= ptr_inc;
    end

    assign ch_next = seq_q ? ptr : addr_q;
endmodule

// File: rtl/cseq_conv_timer.sv
// Conversion timer: busy lasts exactly CONV_CYCLES cycles after a start.
// Assumes: start is only asserted while busy is low.
module cseq_conv_timer #(
    parameter int CONV_CYCLES = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    // Count down the remaining conversion cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(CONV_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cseq_power.sv
// Power-state controller.
// Enters shutdown at the end of a conversion when requested, leaves it on a
// rising start edge, then waits PWRUP_CYCLES cycles before returning active.
// Assumes: PWRUP_CYCLES >= 1.
module cseq_power
    import cseq_pkg::*;
#(
    parameter int PWRUP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_done,
    input  logic       pd_req,
    input  logic       wake,
    output pwr_state_t state
);
    localparam int WCNT_W = $clog2(PWRUP_CYCLES + 1);
    logic [WCNT_W-1:0] wcnt;

    // Step the power state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PWR_ACTIVE;
            wcnt  <= '0;
        end else begin
            unique case (state)
                PWR_ACTIVE: begin
                    if (conv_done && pd_req) state <= PWR_SHUTDOWN;
                end
                PWR_SHUTDOWN: begin
                    if (wake) begin
                        state <= PWR_WAKING;
                        wcnt  <= WCNT_W'(PWRUP_CYCLES - 1);
                    end
                end
                PWR_WAKING: begin
                    if (wcnt == '0) state <= PWR_ACTIVE;
                    else            wcnt  <= wcnt - 1'b1;
                end
                default: state <= PWR_ACTIVE;
            endcase
        end
    end
endmodule

// File: rtl/conv_sequencer.sv
// Multichannel conversion sequencer with shutdown (top level).
// Accepts a start only when idle and active, latches the channel and the
// power-down request at that start, and drives busy and the power state.
// Assumes: conv_start is synchronous unless SYNC_STAGES > 0.
module conv_sequencer
    import cseq_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int CONV_CYCLES  = 14,
    parameter int PWRUP_CYCLES = 8,
    parameter int SYNC_STAGES  = 0,
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            conv_start,
    input  logic            cfg_wr,
    input  logic [CH_W-1:0] cfg_addr,
    input  logic            cfg_seq_en,
    input  logic            cfg_pd,
    output logic            busy,
    output logic [CH_W-1:0] conv_ch,
    output logic [1:0]      pwr_state
);
    logic            st_fall;
    logic            st_rise;
    logic            take;
    logic            done;
    logic            pd_cfg;
    logic            pd_lat;
    logic [CH_W-1:0] ch_next;
    pwr_state_t      pstate;

    cseq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (conv_start),
        .fall (st_fall),
        .rise (st_rise)
    );

    assign take = st_fall && !busy && (pstate == PWR_ACTIVE);

    cseq_chan_sel #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wr_addr(cfg_addr),
        .wr_seq (cfg_seq_en),
        .wr_pd  (cfg_pd),
        .take   (take),
        .ch_next(ch_next),
        .pd_cfg (pd_cfg)
    );

    cseq_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(take),
        .busy (busy),
        .done (done)
    );

    // Latch the channel and the power-down request at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_ch <= '0;
            pd_lat  <= 1'b0;
        end else if (take) begin
            conv_ch <= ch_next;
            pd_lat  <= pd_cfg;
        end
    end

    cseq_power #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_done(done),
        .pd_req   (pd_lat),
        .wake     (st_rise),
        .state    (pstate)
    );

    assign pwr_state = pstate;
endmodule

// File: rtl/conv_sequencer_chk.sv
// Property checker for conv_sequencer, attached with bind.
// Measures busy and power-up run lengths with counters.
module conv_sequencer_chk
    import cseq_pkg::*;
#(
    parameter int CONV_CYCLES  = 14,
    parameter int PWRUP_CYCLES = 8,
    parameter int CH_W         = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_start,
    input logic            busy,
    input logic [CH_W-1:0] conv_ch,
    input logic [1:0]      pwr_state
);
    logic [31:0] busy_run;
    logic [31:0] wake_run;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= '0;
    end

    // Count consecutive power-up cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wake_run <= '0;
        else if (pwr_state == PWR_WAKING) wake_run <= wake_run + 1;
        else                            wake_run <= '0;
    end

    AST_BUSY_AFTER_LOW_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(conv_start)); // R2
    AST_BUSY_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < CONV_CYCLES); // R2
    AST_BUSY_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(busy_run) == CONV_CYCLES - 1); // R2
    AST_CH_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(conv_ch)); // R6
    AST_NO_BUSY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != PWR_ACTIVE) |-> !busy); // R9
    AST_SLEEP_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_SHUTDOWN && $past(pwr_state) != PWR_SHUTDOWN) |-> $fell(busy)); // R8
    AST_WAKE_ON_HIGH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_WAKING && $past(pwr_state) == PWR_SHUTDOWN) |-> $past(conv_start)); // R9
    AST_WAKE_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_WAKING) |-> wake_run < PWRUP_CYCLES); // R9
    AST_WAKE_EXACT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PWR_ACTIVE && $past(pwr_state) == PWR_WAKING) |-> $past(wake_run) == PWRUP_CYCLES - 1); // R9
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'b11); // R1
endmodule

bind conv_sequencer conv_sequencer_chk #(
    .CONV_CYCLES (CONV_CYCLES),
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .CH_W        (CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .busy      (busy),
    .conv_ch   (conv_ch),
    .pwr_state (pwr_state)
);

// File: tb/conv_sequencer_test.sv
// Sweeping bench for conv_sequencer with expected values computed here.
module conv_sequencer_test;
    localparam int NUM_CH = 4;
    localparam int CONV   = 14;
    localparam int PWR    = 8;
    localparam int CH_W   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            conv_start = 1'b1;
    logic            cfg_wr = 1'b0;
    logic [CH_W-1:0] cfg_addr = '0;
    logic            cfg_seq_en = 1'b0;
    logic            cfg_pd = 1'b0;
    logic            busy;
    logic [CH_W-1:0] conv_ch;
    logic [1:0]      pwr_state;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    conv_sequencer #(
        .NUM_CH(NUM_CH), .CONV_CYCLES(CONV), .PWRUP_CYCLES(PWR), .SYNC_STAGES(0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_seq_en(cfg_seq_en), .cfg_pd(cfg_pd),
        .busy(busy), .conv_ch(conv_ch), .pwr_state(pwr_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int addr, input bit seq, input bit pd);
        cfg_wr = 1'b1; cfg_addr = CH_W'(addr); cfg_seq_en = seq; cfg_pd = pd;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    // One conversion from the active state; checks length and channel.
    task automatic run_conv(input int exp_ch, input string req);
        int n = 0;
        conv_start = 1'b1; @(negedge clk);
        conv_start = 1'b0; @(negedge clk);
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk(n == CONV, "R2 busy length", n, CONV);
        chk(conv_ch == CH_W'(exp_ch), req, int'(conv_ch), exp_ch);
        chk(pwr_state == 2'b00, "R8 stays active", int'(pwr_state), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(conv_ch == '0, "R1 channel", int'(conv_ch), 0);
        chk(pwr_state == 2'b00, "R1 power", int'(pwr_state), 0);

        // R3 / R11: fixed channel, two conversions per write
        for (int c = 0; c < NUM_CH; c++) begin
            write_cfg(c, 1'b0, 1'b0);
            run_conv(c, "R3 fixed channel");
            run_conv(c, "R11 fixed channel repeat");
        end

        // R4: sequence 0..last, wrapping
        for (int last = 0; last < NUM_CH; last++) begin
            write_cfg(last, 1'b1, 1'b0);
            for (int i = 0; i < 2 * (last + 1) + 1; i++)
                run_conv(i % (last + 1), "R4 sequence order");
        end

        // R5: a write restarts the sequence
        write_cfg(3, 1'b1, 1'b0);
        run_conv(0, "R5 first");
        run_conv(1, "R5 second");
        write_cfg(3, 1'b1, 1'b0);
        run_conv(0, "R5 restart at 0");

        // R7: falling edge during busy ignored
        write_cfg(3, 1'b1, 1'b0);
        n = 0;
        conv_start = 1'b1; @(negedge clk);
        conv_start = 1'b0; @(negedge clk);
        while (busy && n < 1000) begin
            n++;
            if (n == 2) conv_start = 1'b1;
            if (n == 3) conv_start = 1'b0;
            @(negedge clk);
        end
        chk(n == CONV, "R7 busy not extended", n, CONV);
        chk(conv_ch == 2'd0, "R7 channel", int'(conv_ch), 0);
        run_conv(1, "R7 sequence advanced once");

        // R6: write during conversion deferred
        write_cfg(1, 1'b0, 1'b0);
        n = 0;
        conv_start = 1'b1; @(negedge clk);
        conv_start = 1'b0; @(negedge clk);
        while (busy && n < 1000) begin
            n++;
            if (n == 2) begin cfg_wr = 1'b1; cfg_addr = 2'd2; end
            else cfg_wr = 1'b0;
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        chk(conv_ch == 2'd1, "R6 current channel kept", int'(conv_ch), 1);
        run_conv(2, "R6 new channel next");

        // R8 / R9 / R10: shutdown and power-up
        write_cfg(3, 1'b0, 1'b1);
        n = 0;
        conv_start = 1'b1; @(negedge clk);
        conv_start = 1'b0; @(negedge clk);
        while (busy && n < 1000) begin
            n++;
            if (n == 2) conv_start = 1'b1;
            @(negedge clk);
        end
        chk(n == CONV, "R8 busy length", n, CONV);
        chk(pwr_state == 2'b01, "R8 shutdown on busy fall", int'(pwr_state), 1);
        chk(conv_ch == 2'd3, "R8 channel", int'(conv_ch), 3);
        conv_start = 1'b0; @(negedge clk); @(negedge clk);
        chk(pwr_state == 2'b01, "R9 fall ignored in shutdown", int'(pwr_state), 1);
        chk(busy == 1'b0, "R9 no busy in shutdown", int'(busy), 0);
        conv_start = 1'b1; @(negedge clk);
        w = 0;
        while (pwr_state == 2'b10 && w < 1000) begin
            w++;
            chk(busy == 1'b0, "R10 no busy during power-up", int'(busy), 0);
            if (w == 2) conv_start = 1'b0;
            @(negedge clk);
        end
        chk(w == PWR, "R9 power-up length", w, PWR);
        chk(pwr_state == 2'b00, "R9 active after power-up", int'(pwr_state), 0);
        chk(busy == 1'b0, "R10 fall in power-up ignored", int'(busy), 0);
        write_cfg(3, 1'b0, 1'b0);
        run_conv(3, "R10 conversion after wake");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule